// File: doc/BRIEF.md
# Trap Entry State Saver

This block performs the state bookkeeping a processor core needs when it takes a trap. When a trap request arrives, the block samples the current control state: trap level, global-register level, condition codes, address-space identifier, window pointer, free-window count, processor state word, hypervisor state word and the two program counters. In the same clock edge it commits three things. It raises the trap level by one. It writes an entry on a per-level trap stack. It produces the updated control registers that the handler will run with.

The caller selects one of three entry flavours. A privileged target is the normal case. A hyperprivileged target is the second. A reset/error entry is the third, and it overrides the other two. Each flavour edits the state words in its own way and has its own ceiling on the global level. The window pointer moves according to the trap type, so that window overflow and underflow handlers find a usable window.

Each trap-stack entry holds a packed saved-state word, the masked PC and NPC, the trap type and the pre-trap hypervisor state. The caller reads an entry by giving its level number on an index port. Vector address generation and handler fetch are left to neighbouring logic.

Top module: `trap_entry_saver`

## Requirements
- R1: The saved-state word written for the new level holds the sampled GL in bits 42:40, CCR in 39:32, ASI in 31:24, the 13-bit processor state in 20:8 and the window pointer in 4:0, with every other bit zero.
- R2: Each accepted trap request makes the level output equal the sampled trap level plus one, and the trap-stack entry for that new level is written. The sampled trap level is assumed below MAX_TL.
- R3: When processor-state bit 3 (address mask) is 1, the saved PC and NPC keep only their low 32 bits and the upper bits are zero. When it is 0, all bits are saved.
- R4: The global level output becomes the sampled GL plus one. It saturates at MAX_PGL for a privileged target and at MAX_GL for a hyperprivileged or reset/error entry.
- R5: On a privileged or hyperprivileged entry, processor-state bit 4 (fp enable) becomes 1, and bits 3 (address mask) and 1 (interrupt enable) become 0. All other bits not named in R6/R7 are kept.
- R6: On a privileged target, processor-state bit 2 (privileged) becomes 1 and bit 9 (current little-endian) takes the value of bit 8 (trap little-endian). The hypervisor state word passes through unchanged.
- R7: On a hyperprivileged target, processor-state bit 9 is cleared. In the hypervisor state word, bit 5 (red) and bit 10 (break enable) are cleared and bit 2 (hyperprivileged) is set. Processor-state bit 2 and hypervisor bit 0 (trap-level-zero) are kept.
- R8: The window pointer moves with the trap type. Type 0x24 adds 1. Types 0x80–0xBF add the free-window count plus 2. Types 0xC0–0xFF subtract 1. Any other type leaves it unchanged. All results wrap modulo NWIN.
- R9: On a reset/error entry, the processor state becomes zero except that bit 2 is kept and bit 4 is set. The hypervisor bits 5 and 2 are set, bits 10 and 0 are cleared, and the rest are kept. This entry wins over the hyperprivileged flag.
- R10: The trap-stack entry for the new level also stores the trap type and the hypervisor state word as it was before the trap.
- R11: All updates commit on the clock edge where the request is high, and done is high for exactly the following cycle. Without a request, the control outputs hold their values.
- R12: After reset every control output and every trap-stack entry is zero. Reading level 0, or a level above MAX_TL, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap entry strobe, one cycle per trap |
| trap_type | input | 9 | Trap type number |
| to_hyper | input | 1 | Trap targets hyperprivileged mode |
| to_red | input | 1 | Reset/error entry (overrides to_hyper) |
| tl_in | input | TL_W | Current trap level |
| gl_in | input | 3 | Current global-register level |
| ccr_in | input | 8 | Condition codes |
| asi_in | input | 8 | Address-space identifier |
| cwp_in | input | WIN_W | Current window pointer |
| cansave_in | input | WIN_W | Free-window count |
| pstate_in | input | 13 | Processor state word |
| hpstate_in | input | 12 | Hypervisor state word |
| pc_in | input | PC_W | Trapping PC |
| npc_in | input | PC_W | Next PC |
| rd_lvl | input | TL_W | Trap-stack level to read |
| done | output | 1 | Pulse one cycle after a commit |
| tl_o | output | TL_W | Updated trap level |
| gl_o | output | 3 | Updated global level |
| pstate_o | output | 13 | Updated processor state |
| hpstate_o | output | 12 | Updated hypervisor state |
| cwp_o | output | WIN_W | Updated window pointer |
| rd_tsw | output | 43 | Saved-state word at rd_lvl |
| rd_tpc | output | PC_W | Saved PC at rd_lvl |
| rd_tnpc | output | PC_W | Saved NPC at rd_lvl |
| rd_tt | output | 9 | Saved trap type at rd_lvl |
| rd_hts | output | 12 | Saved pre-trap hypervisor state at rd_lvl |

## Verification
The directed traps are chosen so that different outcomes cannot be confused. A privileged entry with GL already at its ceiling is run next to a hyperprivileged entry from the same GL, which separates the two saturation limits. Processor-state words with the trap little-endian bit both set and clear show whether the copy into bit 9 happens. Types 0x24, a spill number, a fill number and an unrelated type, each at a pointer next to the wrap point, exercise every branch of the window rule. An all-ones processor state on a reset/error entry, sent with the hyperprivileged flag also high, shows both the clearing rule and the priority. Addresses with nonzero upper halves, sent with the mask bit on and off, reveal any truncation fault. A long pseudo-random stream of traps at every level is then checked against the reference model. Each stack level is read back afterwards, which catches writes that land on the wrong level.

// File: rtl/trap_pkg.sv
// trap_pkg: field widths, bit positions and the entry-flavour type shared by
// the trap entry state saver and its checker.
package trap_pkg;
    localparam int TT_W   = 9;
    localparam int GL_W   = 3;
    localparam int CCR_W  = 8;
    localparam int ASI_W  = 8;
    localparam int PS_W   = 13;
    localparam int HPS_W  = 12;
    localparam int TSW_W  = 43;

    // processor state bit positions
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    // hypervisor state bit positions
    localparam int HP_TLZ   = 0;
    localparam int HP_HPRIV = 2;
    localparam int HP_RED   = 5;
    localparam int HP_IBE   = 10;

    typedef enum logic [1:0] {
        TGT_PRIV = 2'd0,
        TGT_HYP  = 2'd1,
        TGT_RED  = 2'd2
    } trap_tgt_e;
endpackage

// File: rtl/trap_cwp_adj.sv
// trap_cwp_adj: computes the window pointer after a trap from the trap type.
// Assumes cwp and cansave are both below NWIN; result wraps modulo NWIN.
module trap_cwp_adj
    import trap_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int WIN_W = $clog2(NWIN),
    localparam int SW = WIN_W + 2
) (
    input  logic [TT_W-1:0]  tt,
    input  logic [WIN_W-1:0] cwp,
    input  logic [WIN_W-1:0] cansave,
    output logic [WIN_W-1:0] cwp_next
);
    logic [SW-1:0] base;

    // select the pre-wrap pointer by trap type class
    always_comb begin
        if (tt == TT_W'(9'h024))
            base = SW'(cwp) + SW'(1);
        else if (tt[TT_W-1:6] == 3'b010)
            base = SW'(cwp) + SW'(cansave) + SW'(2);
        else if (tt[TT_W-1:6] == 3'b011)
            base = SW'(cwp) + SW'(NWIN - 1);
        else
            base = SW'(cwp);
        cwp_next = WIN_W'(base % SW'(NWIN));
    end
endmodule

// File: rtl/trap_ctl_update.sv
// trap_ctl_update: derives the new GL, processor state and hypervisor state
// for the selected entry flavour. Purely combinational.
module trap_ctl_update
    import trap_pkg::*;
#(
    parameter int MAX_PGL = 2,
    parameter int MAX_GL  = 3
) (
    input  trap_tgt_e         tgt,
    input  logic [GL_W-1:0]   gl,
    input  logic [PS_W-1:0]   pstate,
    input  logic [HPS_W-1:0]  hpstate,
    output logic [GL_W-1:0]   gl_next,
    output logic [PS_W-1:0]   pstate_next,
    output logic [HPS_W-1:0]  hpstate_next
);
    logic [GL_W-1:0] cap;

    // saturating GL step with a ceiling chosen by target
    always_comb begin
        cap     = (tgt == TGT_PRIV) ? GL_W'(MAX_PGL) : GL_W'(MAX_GL);
        gl_next = (gl >= cap) ? cap : gl + GL_W'(1);
    end

    // state-word edits per entry flavour
    always_comb begin
        pstate_next  = pstate;
        hpstate_next = hpstate;
        if (tgt == TGT_RED) begin
            pstate_next           = '0;
            pstate_next[PS_PRIV]  = pstate[PS_PRIV];
            pstate_next[PS_PEF]   = 1'b1;
            hpstate_next[HP_RED]  = 1'b1;
            hpstate_next[HP_HPRIV] = 1'b1;
            hpstate_next[HP_IBE]  = 1'b0;
            hpstate_next[HP_TLZ]  = 1'b0;
        end else begin
            pstate_next[PS_PEF] = 1'b1;
            pstate_next[PS_AM]  = 1'b0;
            pstate_next[PS_IE]  = 1'b0;
            if (tgt == TGT_HYP) begin
                pstate_next[PS_CLE]    = 1'b0;
                hpstate_next[HP_RED]   = 1'b0;
                hpstate_next[HP_HPRIV] = 1'b1;
                hpstate_next[HP_IBE]   = 1'b0;
            end else begin
                pstate_next[PS_PRIV] = 1'b1;
                pstate_next[PS_CLE]  = pstate[PS_TLE];
            end
        end
    end
endmodule

// File: rtl/trap_stack.sv
// trap_stack: one saved entry per trap level 1..MAX_TL, written by level
// number and read combinationally by level number. Other levels read zero.
module trap_stack
    import trap_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int PC_W   = 64,
    localparam int TL_W  = $clog2(MAX_TL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TL_W-1:0]   wr_lvl,
    input  logic [TSW_W-1:0]  wr_tsw,
    input  logic [PC_W-1:0]   wr_tpc,
    input  logic [PC_W-1:0]   wr_tnpc,
    input  logic [TT_W-1:0]   wr_tt,
    input  logic [HPS_W-1:0]  wr_hts,
    input  logic [TL_W-1:0]   rd_lvl,
    output logic [TSW_W-1:0]  rd_tsw,
    output logic [PC_W-1:0]   rd_tpc,
    output logic [PC_W-1:0]   rd_tnpc,
    output logic [TT_W-1:0]   rd_tt,
    output logic [HPS_W-1:0]  rd_hts
);
    logic [TSW_W-1:0] e_tsw  [MAX_TL];
    logic [PC_W-1:0]  e_tpc  [MAX_TL];
    logic [PC_W-1:0]  e_tnpc [MAX_TL];
    logic [TT_W-1:0]  e_tt   [MAX_TL];
    logic [HPS_W-1:0] e_hts  [MAX_TL];

    for (genvar g = 0; g < MAX_TL; g++) begin : g_lvl
        // entry g holds trap level g+1
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_tsw[g]  <= '0;
                e_tpc[g]  <= '0;
                e_tnpc[g] <= '0;
                e_tt[g]   <= '0;
                e_hts[g]  <= '0;
            end else if (wr_en && wr_lvl == TL_W'(g + 1)) begin
                e_tsw[g]  <= wr_tsw;
                e_tpc[g]  <= wr_tpc;
                e_tnpc[g] <= wr_tnpc;
                e_tt[g]   <= wr_tt;
                e_hts[g]  <= wr_hts;
            end
        end
    end

    // indexed read; unmatched levels return zero
    always_comb begin
        rd_tsw  = '0;
        rd_tpc  = '0;
        rd_tnpc = '0;
        rd_tt   = '0;
        rd_hts  = '0;
        for (int i = 0; i < MAX_TL; i++) begin
            if (rd_lvl == TL_W'(i + 1)) begin
                rd_tsw  = e_tsw[i];
                rd_tpc  = e_tpc[i];
                rd_tnpc = e_tnpc[i];
                rd_tt   = e_tt[i];
                rd_hts  = e_hts[i];
            end
        end
    end
endmodule

// File: rtl/trap_entry_saver.sv
// trap_entry_saver: on a one-cycle trap request, saves the pre-trap state on
// the trap stack at the new level and commits the updated control registers
// in the same edge; done follows one cycle later. Assumes tl_in < MAX_TL,
// cwp_in < NWIN and cansave_in < NWIN.
module trap_entry_saver
    import trap_pkg::*;
#(
    parameter int MAX_TL  = 6,
    parameter int MAX_PGL = 2,
    parameter int MAX_GL  = 3,
    parameter int NWIN    = 8,
    parameter int PC_W    = 64,
    localparam int TL_W   = $clog2(MAX_TL + 1),
    localparam int WIN_W  = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [TT_W-1:0]   trap_type,
    input  logic              to_hyper,
    input  logic              to_red,
    input  logic [TL_W-1:0]   tl_in,
    input  logic [GL_W-1:0]   gl_in,
    input  logic [CCR_W-1:0]  ccr_in,
    input  logic [ASI_W-1:0]  asi_in,
    input  logic [WIN_W-1:0]  cwp_in,
    input  logic [WIN_W-1:0]  cansave_in,
    input  logic [PS_W-1:0]   pstate_in,
    input  logic [HPS_W-1:0]  hpstate_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   npc_in,
    input  logic [TL_W-1:0]   rd_lvl,
    output logic              done,
    output logic [TL_W-1:0]   tl_o,
    output logic [GL_W-1:0]   gl_o,
    output logic [PS_W-1:0]   pstate_o,
    output logic [HPS_W-1:0]  hpstate_o,
    output logic [WIN_W-1:0]  cwp_o,
    output logic [TSW_W-1:0]  rd_tsw,
    output logic [PC_W-1:0]   rd_tpc,
    output logic [PC_W-1:0]   rd_tnpc,
    output logic [TT_W-1:0]   rd_tt,
    output logic [HPS_W-1:0]  rd_hts
);
    trap_tgt_e        tgt;
    logic [TL_W-1:0]  lvl_next;
    logic [TSW_W-1:0] tsw;
    logic [PC_W-1:0]  pc_mask;
    logic [GL_W-1:0]  gl_next;
    logic [PS_W-1:0]  ps_next;
    logic [HPS_W-1:0] hps_next;
    logic [WIN_W-1:0] cwp_next;

    // entry flavour: reset/error overrides hyperprivileged
    assign tgt      = to_red ? TGT_RED : (to_hyper ? TGT_HYP : TGT_PRIV);
    assign lvl_next = tl_in + TL_W'(1);

    // pack the saved-state word
    always_comb begin
        tsw          = '0;
        tsw[42:40]   = gl_in;
        tsw[39:32]   = ccr_in;
        tsw[31:24]   = asi_in;
        tsw[20:8]    = pstate_in;
        tsw[4:0]     = 5'(cwp_in);
    end

    // address-mask truncation of saved program counters
    assign pc_mask = pstate_in[PS_AM] ? PC_W'(32'hFFFF_FFFF) : '1;

    trap_ctl_update #(.MAX_PGL(MAX_PGL), .MAX_GL(MAX_GL)) u_ctl (
        .tgt          (tgt),
        .gl           (gl_in),
        .pstate       (pstate_in),
        .hpstate      (hpstate_in),
        .gl_next      (gl_next),
        .pstate_next  (ps_next),
        .hpstate_next (hps_next)
    );

    trap_cwp_adj #(.NWIN(NWIN)) u_cwp (
        .tt       (trap_type),
        .cwp      (cwp_in),
        .cansave  (cansave_in),
        .cwp_next (cwp_next)
    );

    trap_stack #(.MAX_TL(MAX_TL), .PC_W(PC_W)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (trap_req),
        .wr_lvl  (lvl_next),
        .wr_tsw  (tsw),
        .wr_tpc  (pc_in & pc_mask),
        .wr_tnpc (npc_in & pc_mask),
        .wr_tt   (trap_type),
        .wr_hts  (hpstate_in),
        .rd_lvl  (rd_lvl),
        .rd_tsw  (rd_tsw),
        .rd_tpc  (rd_tpc),
        .rd_tnpc (rd_tnpc),
        .rd_tt   (rd_tt),
        .rd_hts  (rd_hts)
    );

    // commit control registers on a request; pulse done the cycle after
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            tl_o      <= '0;
            gl_o      <= '0;
            pstate_o  <= '0;
            hpstate_o <= '0;
            cwp_o     <= '0;
        end else begin
            done <= trap_req;
            if (trap_req) begin
                tl_o      <= lvl_next;
                gl_o      <= gl_next;
                pstate_o  <= ps_next;
                hpstate_o <= hps_next;
                cwp_o     <= cwp_next;
            end
        end
    end
endmodule

// File: rtl/trap_entry_saver_chk.sv
// trap_entry_saver_chk: temporal properties of the trap entry state saver,
// attached to every instance by bind.
module trap_entry_saver_chk
    import trap_pkg::*;
#(
    parameter int MAX_TL  = 6,
    parameter int MAX_PGL = 2,
    parameter int MAX_GL  = 3,
    parameter int NWIN    = 8,
    localparam int TL_W   = $clog2(MAX_TL + 1),
    localparam int WIN_W  = $clog2(NWIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_req,
    input logic              to_hyper,
    input logic              to_red,
    input logic [TL_W-1:0]   tl_in,
    input logic [PS_W-1:0]   pstate_in,
    input logic              done,
    input logic [TL_W-1:0]   tl_o,
    input logic [GL_W-1:0]   gl_o,
    input logic [PS_W-1:0]   pstate_o,
    input logic [HPS_W-1:0]  hpstate_o,
    input logic [WIN_W-1:0]  cwp_o
);
    p_tl_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> tl_o == TL_W'($past(tl_in) + TL_W'(1)));

    p_priv_gl_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !to_red && !to_hyper) |=> gl_o <= GL_W'(MAX_PGL));

    p_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !to_red) |=> pstate_o[PS_PEF] && !pstate_o[PS_AM] && !pstate_o[PS_IE]);

    p_priv_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !to_red && !to_hyper) |=>
            pstate_o[PS_PRIV] && (pstate_o[PS_CLE] == $past(pstate_in[PS_TLE])));

    p_hyp_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && to_hyper && !to_red) |=>
            hpstate_o[HP_HPRIV] && !hpstate_o[HP_RED] && !hpstate_o[HP_IBE] && !pstate_o[PS_CLE]);

    p_red_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && to_red |=>
            hpstate_o[HP_RED] && hpstate_o[HP_HPRIV] && !hpstate_o[HP_TLZ] && pstate_o[PS_PEF]);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> !done);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> $stable(tl_o) && $stable(gl_o) && $stable(pstate_o)
                      && $stable(hpstate_o) && $stable(cwp_o));
endmodule

bind trap_entry_saver trap_entry_saver_chk #(
    .MAX_TL(MAX_TL), .MAX_PGL(MAX_PGL), .MAX_GL(MAX_GL), .NWIN(NWIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req),
    .to_hyper  (to_hyper),
    .to_red    (to_red),
    .tl_in     (tl_in),
    .pstate_in (pstate_in),
    .done      (done),
    .tl_o      (tl_o),
    .gl_o      (gl_o),
    .pstate_o  (pstate_o),
    .hpstate_o (hpstate_o),
    .cwp_o     (cwp_o)
);

// File: tb/trap_entry_saver_tb.sv
// Bench: behavioural reference model updated at each rising edge, compared
// against every output at each falling edge.
module trap_entry_saver_tb;
    localparam int MAX_TL = 6, MAX_PGL = 2, MAX_GL = 3, NWIN = 8, PC_W = 64;
    localparam int TL_W = $clog2(MAX_TL + 1), WIN_W = $clog2(NWIN);

    logic clk = 1'b0, rst_n = 1'b0;
    logic trap_req = 1'b0, to_hyper = 1'b0, to_red = 1'b0;
    logic [8:0] trap_type = '0;
    logic [TL_W-1:0] tl_in = '0, rd_lvl = '0;
    logic [2:0] gl_in = '0;
    logic [7:0] ccr_in = '0, asi_in = '0;
    logic [WIN_W-1:0] cwp_in = '0, cansave_in = '0;
    logic [12:0] pstate_in = '0;
    logic [11:0] hpstate_in = '0;
    logic [PC_W-1:0] pc_in = '0, npc_in = '0;
    logic done;
    logic [TL_W-1:0] tl_o;
    logic [2:0] gl_o;
    logic [12:0] pstate_o;
    logic [11:0] hpstate_o;
    logic [WIN_W-1:0] cwp_o;
    logic [42:0] rd_tsw;
    logic [PC_W-1:0] rd_tpc, rd_tnpc;
    logic [8:0] rd_tt;
    logic [11:0] rd_hts;

    int checks = 0, errors = 0;
    bit finished = 0, armed = 0;

    trap_entry_saver #(.MAX_TL(MAX_TL), .MAX_PGL(MAX_PGL), .MAX_GL(MAX_GL),
                       .NWIN(NWIN), .PC_W(PC_W)) u_dut (.*);

    always #10 clk = ~clk;

    // reference model state
    logic m_done;
    logic [63:0] m_tl, m_gl, m_ps, m_hp, m_cwp;
    logic [63:0] m_tsw [1:MAX_TL];
    logic [63:0] m_tpc [1:MAX_TL];
    logic [63:0] m_tnpc[1:MAX_TL];
    logic [63:0] m_tt  [1:MAX_TL];
    logic [63:0] m_hts [1:MAX_TL];
    string m_mode = "R12";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_done = 0; m_tl = 0; m_gl = 0; m_ps = 0; m_hp = 0; m_cwp = 0;
            for (int i = 1; i <= MAX_TL; i++) begin
                m_tsw[i] = 0; m_tpc[i] = 0; m_tnpc[i] = 0; m_tt[i] = 0; m_hts[i] = 0;
            end
        end else begin
            m_done = trap_req;
            if (trap_req) begin
                int lvl, cap, c, t;
                logic [63:0] msk, p, h;
                lvl = int'(tl_in) + 1;
                cap = (!to_red && !to_hyper) ? MAX_PGL : MAX_GL;
                m_tl = 64'(lvl);
                m_gl = 64'((int'(gl_in) + 1 > cap) ? cap : int'(gl_in) + 1);
                msk = pstate_in[3] ? 64'h0000_0000_FFFF_FFFF : '1;
                p = 64'(pstate_in); h = 64'(hpstate_in);
                if (to_red) begin
                    m_mode = "R9";
                    p = (p & 64'h4) | 64'h10;
                    h = (h | 64'h24) & ~64'h401;
                end else begin
                    p = (p | 64'h10) & ~64'h0A;
                    if (to_hyper) begin
                        m_mode = "R7";
                        p = p & ~64'h200;
                        h = (h | 64'h4) & ~64'h420;
                    end else begin
                        m_mode = "R6";
                        p = p | 64'h4;
                        p = pstate_in[8] ? (p | 64'h200) : (p & ~64'h200);
                    end
                end
                m_ps = p; m_hp = h;
                t = int'(trap_type); c = int'(cwp_in);
                if (t == 'h24) c = c + 1;
                else if (t >= 'h80 && t <= 'hBF) c = c + int'(cansave_in) + 2;
                else if (t >= 'hC0 && t <= 'hFF) c = c + NWIN - 1;
                m_cwp = 64'(c % NWIN);
                if (lvl <= MAX_TL) begin
                    m_tsw[lvl]  = (64'(gl_in) << 40) | (64'(ccr_in) << 32) |
                                  (64'(asi_in) << 24) | (64'(pstate_in) << 8) | 64'(cwp_in);
                    m_tpc[lvl]  = pc_in & msk;
                    m_tnpc[lvl] = npc_in & msk;
                    m_tt[lvl]   = 64'(trap_type);
                    m_hts[lvl]  = 64'(hpstate_in);
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (armed && rst_n) begin
            int l;
            l = int'(rd_lvl);
            chk("R11", "done", 64'(done), 64'(m_done));
            chk("R2", "tl", 64'(tl_o), m_tl);
            chk("R4", "gl", 64'(gl_o), m_gl);
            chk(m_mode, "pstate", 64'(pstate_o), m_ps);
            chk(m_mode, "hpstate", 64'(hpstate_o), m_hp);
            chk("R8", "cwp", 64'(cwp_o), m_cwp);
            if (l >= 1 && l <= MAX_TL) begin
                chk("R1", "tsw", 64'(rd_tsw), m_tsw[l]);
                chk("R3", "tpc", rd_tpc, m_tpc[l]);
                chk("R3", "tnpc", rd_tnpc, m_tnpc[l]);
                chk("R10", "tt", 64'(rd_tt), m_tt[l]);
                chk("R10", "hts", 64'(rd_hts), m_hts[l]);
            end else begin
                chk("R12", "empty level", 64'(rd_tsw) | rd_tpc | rd_tnpc | 64'(rd_tt) | 64'(rd_hts), 0);
            end
        end
    end

    task automatic trap(input logic [8:0] tt, input logic hyp, input logic red,
                        input int tl, input int gl, input int cwp, input int cs,
                        input logic [12:0] ps, input logic [11:0] hp,
                        input logic [63:0] pc);
        @(negedge clk); #1;
        trap_type = tt; to_hyper = hyp; to_red = red;
        tl_in = TL_W'(tl); gl_in = 3'(gl); cwp_in = WIN_W'(cwp); cansave_in = WIN_W'(cs);
        pstate_in = ps; hpstate_in = hp; pc_in = pc; npc_in = pc + 64'd4;
        ccr_in = 8'($urandom); asi_in = 8'($urandom);
        rd_lvl = TL_W'(tl + 1);
        trap_req = 1'b1;
        @(negedge clk); #1;
        trap_req = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state of every output
        chk("R12", "done", 64'(done), 0);
        chk("R12", "tl", 64'(tl_o), 0);
        chk("R12", "gl", 64'(gl_o), 0);
        chk("R12", "pstate", 64'(pstate_o), 0);
        chk("R12", "hpstate", 64'(hpstate_o), 0);
        chk("R12", "cwp", 64'(cwp_o), 0);
        armed = 1;
        // R6, R8: window +1, tle copied to cle
        trap(9'h024, 0, 0, 0, 0, 7, 0, 13'h10A, 12'h421, 64'hDEAD_BEEF_0000_1000);
        // R4: privileged GL saturates at MAX_PGL; R8 spill wrap
        trap(9'h085, 0, 0, 1, 2, 6, 3, 13'h000, 12'h000, 64'h1234_5678_9ABC_DEF0);
        // R4, R7: hyperprivileged GL from the same level climbs to MAX_GL
        trap(9'h0C3, 1, 0, 2, 2, 0, 0, 13'h3FE, 12'h425, 64'hFFFF_0000_AAAA_5554);
        // R3: address mask truncates saved PCs; R4 hyper cap holds at MAX_GL
        trap(9'h030, 1, 0, 3, 3, 4, 2, 13'h008, 12'h001, 64'hCAFE_F00D_1234_0008);
        // R9: reset/error entry wins over hyper flag, clears pstate except priv
        trap(9'h030, 1, 1, 4, 1, 3, 1, 13'h1FFF, 12'h401, 64'h0000_0001_0000_0000);
        // R6: tle clear gives cle clear; type outside classes keeps cwp
        trap(9'h100, 0, 0, 5, 0, 5, 5, 13'h208, 12'h024, 64'h8000_0000_0000_0010);
        // idle cycles: R11 hold
        repeat (4) @(negedge clk);
        // pseudo-random stream
        for (int k = 0; k < 60; k++) begin
            logic [8:0] tt;
            case ($urandom % 5)
                0: tt = 9'h024;
                1: tt = 9'h080 | 9'($urandom % 64);
                2: tt = 9'h0C0 | 9'($urandom % 64);
                default: tt = 9'($urandom);
            endcase
            trap(tt, 1'($urandom), ($urandom % 6) == 0, int'($urandom % MAX_TL),
                 int'($urandom % 8), int'($urandom % NWIN), int'($urandom % NWIN),
                 13'($urandom), 12'($urandom), {$urandom, $urandom});
        end
        // R12 / R10: sweep read port across all levels, including 0 and MAX_TL+1
        for (int l = 0; l <= MAX_TL + 1; l++) begin
            @(negedge clk); #1 rd_lvl = TL_W'(l);
            @(negedge clk);
        end
        @(negedge clk);
        finish_run();
    end
endmodule